// File: doc/BRIEF.md
# Shadow-Register Reconfigurable Functional Unit

This block is a reconfigurable functional unit that sits next to a processor's integer register file. It keeps its own copy of a fixed window of host registers: whenever the host writes a register whose index falls inside that window, the matching shadow entry takes the same value at the same clock edge. A stack of combinational cell rows, one cell per bit of the data word, computes continuously from those shadow copies. No operand is ever sent to the unit.

Software places operands in the mirrored registers, waits as many cycles as the loaded function needs to settle, and then issues a result fetch. The fetch captures the array output into a result register that the host writes back to the requested destination register. A small configuration store holds several complete array programs. A one-cycle context switch selects which program drives the rows.

Each row applies one 3-input lookup function to all bit positions. Each of the function's three inputs comes from a shadow entry, from the row above at the same bit, or from the row above at the next lower bit.

Top module: `srfu_top`

## Requirements
- R1: After reset, res_valid is 0, the active context is 0, every shadow entry is 0 and every stored row word is 0, so a fetch returns 0.
- R2: A host write (hw_we=1) to index k with SH_BASE <= k < SH_BASE+NSH (default 8..16) sets shadow entry k-SH_BASE at that clock edge. A fetch in the next cycle sees the new value.
- R3: A host write to an index outside the mirrored window leaves every shadow entry unchanged, so a later fetch is unaffected.
- R4: A fetch (fetch_req=1) in a cycle with ctx_sw=0 gives exactly one cycle with res_valid=1 in the next cycle, res_rd equal to fetch_rd, and res_data equal to the array output for that cycle's shadow contents and active context. With no fetch, res_valid is 0 in the next cycle.
- R5: The rows are evaluated in order 0..ROWS-1, and the result is the last row. For row r and bit i, the output is lut[{a,b,c}], with a as the most significant bit of the index. Each of a, b and c is chosen by a 4-bit source code: 0..NSH-1 gives shadow entry bit i; NSH (9) gives the previous row's bit i; NSH+1 (10) gives the previous row's bit i-1, which is 0 at i=0; any other code gives 0. Row 0 treats the previous row as all zeros.
- R6: cfg_we=1 stores cfg_word into row cfg_row of context cfg_ctx at the clock edge. The fields are lut in bits 7:0, the a-select in 11:8, the b-select in 15:12 and the c-select in 19:16. A cfg_row of ROWS or more is ignored. The new word takes effect from the next cycle.
- R7: ctx_sw=1 makes ctx_new the active context from the next cycle. Stored programs of all contexts are retained across switches.
- R8: A fetch in a cycle with ctx_sw=1 is stalled: fetch_stall is 1 in that cycle and no result appears in the next cycle. The host re-issues the fetch, which then completes with the new context.
- R9: A fetch in the same cycle as a host write to a mirrored register sees the shadow contents from before that write.
- R10: Writing a row word into a context other than the active one does not change the fetched result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_we | input | 1 | Host register write enable |
| hw_idx | input | IDX_W (5) | Host register write index |
| hw_data | input | XLEN (32) | Host register write data |
| cfg_we | input | 1 | Configuration row write enable |
| cfg_ctx | input | CTX_W (2) | Context written by cfg_we |
| cfg_row | input | ROW_W (2) | Row written by cfg_we |
| cfg_word | input | 20 | Row word: lut, a/b/c source selects |
| ctx_sw | input | 1 | Context switch request |
| ctx_new | input | CTX_W (2) | Context made active by ctx_sw |
| fetch_req | input | 1 | Result fetch request |
| fetch_rd | input | IDX_W (5) | Destination register of the fetch |
| fetch_stall | output | 1 | Fetch refused this cycle; re-issue it |
| res_valid | output | 1 | Result write-back valid |
| res_rd | output | IDX_W (5) | Destination register of the result |
| res_data | output | XLEN (32) | Fetched array result |

## Verification
On every cycle the assertions check the timing and bookkeeping around the array. They check that a mirrored write lands in exactly the addressed shadow entry and that other writes leave the shadow contents stable. They check that an accepted fetch produces a one-cycle result carrying the captured array value and destination, that a fetch in a switch cycle yields nothing, and that the active context changes only on a switch. The correctness of the row function itself (the lookup indexing, the source codes, the lower-bit neighbour at bit 0), the retention of inactive contexts and the ordering of a write against a same-cycle fetch are shown only by the bench. Its reference model recomputes the result from its own copies of the registers and programs under directed and random stimulus.

// File: rtl/srfu_pkg.sv
package srfu_pkg;
  localparam int SEL_W = 4;
  localparam int LUT_W = 8;
  localparam int CFG_W = LUT_W + 3 * SEL_W;

  // one row program: uniform 3-input function plus its three source codes
  typedef struct packed {
    logic [SEL_W-1:0] sel_c;
    logic [SEL_W-1:0] sel_b;
    logic [SEL_W-1:0] sel_a;
    logic [LUT_W-1:0] lut;
  } row_cfg_t;

  function automatic logic lut3(input logic [LUT_W-1:0] t, input logic a,
                                input logic b, input logic c);
    return t[{a, b, c}];
  endfunction
endpackage

// File: rtl/srfu_shadow_file.sv
module srfu_shadow_file #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5,
  parameter int NSH   = 9,
  parameter int BASE  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [XLEN-1:0]           wr_data,
  output logic [NSH-1:0][XLEN-1:0]  shadow,
  output logic                      hit
);
  assign hit = wr_en && (int'(wr_idx) >= BASE) && (int'(wr_idx) < BASE + NSH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
    end else begin
      for (int j = 0; j < NSH; j++) begin
        if (wr_en && (wr_idx == IDX_W'(BASE + j))) shadow[j] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/srfu_cfg_cache.sv
module srfu_cfg_cache import srfu_pkg::*; #(
  parameter int NCTX  = 4,
  parameter int ROWS  = 3,
  parameter int CTX_W = 2,
  parameter int ROW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTX_W-1:0] wctx,
  input  logic [ROW_W-1:0] wrow,
  input  row_cfg_t         wword,
  input  logic [CTX_W-1:0] rctx,
  output row_cfg_t         rows_o [ROWS]
);
  row_cfg_t mem [NCTX][ROWS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCTX; c++)
        for (int r = 0; r < ROWS; r++) mem[c][r] <= '0;
    end else if (we) begin
      for (int c = 0; c < NCTX; c++)
        for (int r = 0; r < ROWS; r++)
          if (wctx == CTX_W'(c) && wrow == ROW_W'(r)) mem[c][r] <= wword;
    end
  end

  always_comb begin
    for (int r = 0; r < ROWS; r++) rows_o[r] = mem[rctx][r];
  end
endmodule

// File: rtl/srfu_cell_array.sv
module srfu_cell_array import srfu_pkg::*; #(
  parameter int XLEN = 32,
  parameter int NSH  = 9,
  parameter int ROWS = 3
) (
  input  logic [NSH-1:0][XLEN-1:0] shadow,
  input  row_cfg_t                 cfg [ROWS],
  output logic [XLEN-1:0]          result
);
  localparam int SRC_UP   = NSH;
  localparam int SRC_UPDN = NSH + 1;

  function automatic logic pick(input logic [SEL_W-1:0] sel, input logic [NSH-1:0] col,
                                input logic up, input logic updn);
    if (int'(sel) < NSH)        return col[sel];
    else if (int'(sel) == SRC_UP)   return up;
    else if (int'(sel) == SRC_UPDN) return updn;
    else                        return 1'b0;
  endfunction

  logic [ROWS-1:0][XLEN-1:0] row_out;
  logic [XLEN-1:0][NSH-1:0]  column;

  always_comb begin
    for (int i = 0; i < XLEN; i++)
      for (int j = 0; j < NSH; j++) column[i][j] = shadow[j][i];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [XLEN-1:0] above;
    if (r == 0) begin : g_top
      assign above = '0;
    end else begin : g_mid
      assign above = row_out[r-1];
    end
    for (genvar i = 0; i < XLEN; i++) begin : g_cell
      logic up_dn;
      if (i == 0) begin : g_lsb
        assign up_dn = 1'b0;
      end else begin : g_bit
        assign up_dn = above[i-1];
      end
      assign row_out[r][i] = lut3(cfg[r].lut,
                                  pick(cfg[r].sel_a, column[i], above[i], up_dn),
                                  pick(cfg[r].sel_b, column[i], above[i], up_dn),
                                  pick(cfg[r].sel_c, column[i], above[i], up_dn));
    end
  end

  assign result = row_out[ROWS-1];
endmodule

// File: rtl/srfu_top.sv
module srfu_top import srfu_pkg::*; #(
  parameter int XLEN    = 32,
  parameter int IDX_W   = 5,
  parameter int NSH     = 9,
  parameter int SH_BASE = 8,
  parameter int NCTX    = 4,
  parameter int ROWS    = 3,
  localparam int CTX_W  = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_we,
  input  logic [IDX_W-1:0] hw_idx,
  input  logic [XLEN-1:0]  hw_data,
  input  logic             cfg_we,
  input  logic [CTX_W-1:0] cfg_ctx,
  input  logic [ROW_W-1:0] cfg_row,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             ctx_sw,
  input  logic [CTX_W-1:0] ctx_new,
  input  logic             fetch_req,
  input  logic [IDX_W-1:0] fetch_rd,
  output logic             fetch_stall,
  output logic             res_valid,
  output logic [IDX_W-1:0] res_rd,
  output logic [XLEN-1:0]  res_data
);
  logic [NSH-1:0][XLEN-1:0] shadow_q;
  logic                     shadow_hit;
  row_cfg_t                 act_rows [ROWS];
  logic [XLEN-1:0]          array_out;
  logic [CTX_W-1:0]         active_ctx;
  logic                     fetch_accept;

  srfu_shadow_file #(.XLEN(XLEN), .IDX_W(IDX_W), .NSH(NSH), .BASE(SH_BASE)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(hw_we), .wr_idx(hw_idx), .wr_data(hw_data),
    .shadow(shadow_q), .hit(shadow_hit));

  srfu_cfg_cache #(.NCTX(NCTX), .ROWS(ROWS), .CTX_W(CTX_W), .ROW_W(ROW_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wctx(cfg_ctx), .wrow(cfg_row),
    .wword(row_cfg_t'(cfg_word)), .rctx(active_ctx), .rows_o(act_rows));

  srfu_cell_array #(.XLEN(XLEN), .NSH(NSH), .ROWS(ROWS)) u_array (
    .shadow(shadow_q), .cfg(act_rows), .result(array_out));

  // a switch cycle refuses the fetch; the host re-issues it next cycle
  assign fetch_accept = fetch_req && !ctx_sw;
  assign fetch_stall  = fetch_req && ctx_sw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_ctx <= '0;
      res_valid  <= 1'b0;
      res_rd     <= '0;
      res_data   <= '0;
    end else begin
      if (ctx_sw) active_ctx <= ctx_new;
      res_valid <= fetch_accept;
      if (fetch_accept) begin
        res_rd   <= fetch_rd;
        res_data <= array_out;
      end
    end
  end
endmodule

// File: rtl/srfu_checker.sv
module srfu_checker #(
  parameter int XLEN    = 32,
  parameter int IDX_W   = 5,
  parameter int NSH     = 9,
  parameter int SH_BASE = 8,
  parameter int CTX_W   = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     hw_we,
  input logic [IDX_W-1:0]         hw_idx,
  input logic [XLEN-1:0]          hw_data,
  input logic                     ctx_sw,
  input logic [CTX_W-1:0]         ctx_new,
  input logic                     fetch_req,
  input logic [IDX_W-1:0]         fetch_rd,
  input logic                     res_valid,
  input logic [IDX_W-1:0]         res_rd,
  input logic [XLEN-1:0]          res_data,
  input logic [CTX_W-1:0]         active_ctx,
  input logic [XLEN-1:0]          array_out,
  input logic                     shadow_hit,
  input logic [NSH-1:0][XLEN-1:0] shadow_q
);
  logic             pend;
  logic [IDX_W-1:0] pslot;
  logic [XLEN-1:0]  pdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      pslot <= '0;
      pdata <= '0;
    end else begin
      pend  <= hw_we && shadow_hit;
      pslot <= hw_idx - IDX_W'(SH_BASE);
      pdata <= hw_data;
    end
  end

  AST_SHADOW_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> shadow_q[pslot] == pdata); // R2
  AST_SHADOW_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !(hw_we && shadow_hit) |=> $stable(shadow_q)); // R3
  AST_RESULT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !ctx_sw) |=> res_valid && res_rd == $past(fetch_rd)
                               && res_data == $past(array_out)); // R4
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_req |=> !res_valid); // R4
  AST_SWITCH_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_sw |=> active_ctx == $past(ctx_new)); // R7
  AST_CTX_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_sw |=> $stable(active_ctx)); // R7
  AST_STALL_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && ctx_sw) |=> !res_valid); // R8
endmodule

bind srfu_top srfu_checker #(.XLEN(XLEN), .IDX_W(IDX_W), .NSH(NSH), .SH_BASE(SH_BASE),
                             .CTX_W(CTX_W)) u_chk (.*);

// File: tb/tb_srfu_top.sv
module tb_srfu_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hw_we;
  logic [4:0]  hw_idx;
  logic [31:0] hw_data;
  logic        cfg_we;
  logic [1:0]  cfg_ctx;
  logic [1:0]  cfg_row;
  logic [19:0] cfg_word;
  logic        ctx_sw;
  logic [1:0]  ctx_new;
  logic        fetch_req;
  logic [4:0]  fetch_rd;
  logic        fetch_stall;
  logic        res_valid;
  logic [4:0]  res_rd;
  logic [31:0] res_data;

  always #5 clk = ~clk;

  srfu_top dut (.*);

  // reference model state
  logic [31:0] sh [9];
  logic [19:0] prog [4][3];
  int          act;
  logic        e_valid;
  logic [4:0]  e_rd;
  logic [31:0] e_data;
  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R1";

  function automatic logic src(input int code, input int i, input logic [31:0] prev);
    if (code < 9) return sh[code][i];
    if (code == 9) return prev[i];
    if (code == 10) return (i == 0) ? 1'b0 : prev[i-1];
    return 1'b0;
  endfunction

  function automatic logic [31:0] model_eval();
    logic [31:0] prev = 32'h0, cur;
    for (int r = 0; r < 3; r++) begin
      logic [19:0] w = prog[act][r];
      for (int i = 0; i < 32; i++) begin
        int k = 4 * int'(src(int'(w[11:8]), i, prev)) + 2 * int'(src(int'(w[15:12]), i, prev))
                + int'(src(int'(w[19:16]), i, prev));
        cur[i] = w[k];
      end
      prev = cur;
    end
    return prev;
  endfunction

  function automatic logic [19:0] mk(input logic [7:0] lut, input int a, input int b, input int c);
    return {4'(c), 4'(b), 4'(a), lut};
  endfunction

  task automatic model_step();
    e_valid = fetch_req && !ctx_sw;
    if (e_valid) begin
      e_rd   = fetch_rd;
      e_data = model_eval();
    end
    if (hw_we && hw_idx >= 8 && hw_idx <= 16) sh[int'(hw_idx) - 8] = hw_data;
    if (cfg_we && cfg_row < 3) prog[cfg_ctx][cfg_row] = cfg_word;
    if (ctx_sw) act = int'(ctx_new);
  endtask

  task automatic compare();
    logic ok;
    ok = (res_valid === e_valid) && (fetch_stall === (fetch_req && ctx_sw));
    if (e_valid) ok = ok && (res_rd === e_rd) && (res_data === e_data);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual valid=%b rd=%0d data=%h stall=%b expected valid=%b rd=%0d data=%h stall=%b",
               tag, res_valid, res_rd, res_data, fetch_stall, e_valid, e_rd, e_data,
               fetch_req && ctx_sw);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic quiet();
    hw_we = 0; cfg_we = 0; ctx_sw = 0; fetch_req = 0;
  endtask

  task automatic hwrite(input int idx, input logic [31:0] d);
    quiet(); hw_we = 1; hw_idx = 5'(idx); hw_data = d; tick(); quiet();
  endtask

  task automatic cwrite(input int c, input int r, input logic [19:0] w);
    quiet(); cfg_we = 1; cfg_ctx = 2'(c); cfg_row = 2'(r); cfg_word = w; tick(); quiet();
  endtask

  task automatic fetch(input int rd);
    quiet(); fetch_req = 1; fetch_rd = 5'(rd); tick(); quiet(); tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < 9; j++) sh[j] = 0;
    for (int c = 0; c < 4; c++) for (int r = 0; r < 3; r++) prog[c][r] = 0;
    act = 0; e_valid = 0; e_rd = 0; e_data = 0;
    rst_n = 0; hw_idx = 0; hw_data = 0; cfg_ctx = 0; cfg_row = 0; cfg_word = 0;
    ctx_new = 0; fetch_rd = 0; quiet();
    repeat (3) @(negedge clk);
    tag = "R1"; compare();                    // R1 reset state
    rst_n = 1;
    fetch(3);                                 // R1 zero result

    // R5/R6: ctx0 = ((sh0 & sh1) passed down) ^ sh2
    tag = "R6";
    cwrite(0, 0, mk(8'hC0, 0, 1, 11));
    cwrite(0, 1, mk(8'hF0, 9, 11, 11));
    cwrite(0, 2, mk(8'h3C, 9, 2, 11));
    tag = "R2";
    hwrite(8, 32'hF0F0_1234); hwrite(9, 32'hFF00_FF0F); hwrite(10, 32'h0000_FFFF);
    tag = "R5"; fetch(12);
    // ctx1 = (shift-up of (sh3 ^ sh4)) | sh8 ; exercises code 10 and the top entry
    tag = "R6";
    cwrite(1, 0, mk(8'h3C, 3, 4, 11));
    cwrite(1, 1, mk(8'hF0, 10, 11, 11));
    cwrite(1, 2, mk(8'hFC, 9, 8, 11));
    cwrite(1, 3, mk(8'hFF, 0, 0, 0));          // R6 row beyond ROWS ignored
    tag = "R2";
    hwrite(11, 32'h8000_0001); hwrite(12, 32'h0F0F_0F0F); hwrite(16, 32'h0000_0100);
    tag = "R7";
    quiet(); ctx_sw = 1; ctx_new = 1; tick(); quiet();
    fetch(20);
    tag = "R5"; fetch(7);
    tag = "R3";
    hwrite(3, 32'hDEAD_BEEF); hwrite(17, 32'h1234_5678); hwrite(31, 32'hFFFF_FFFF);
    fetch(21);
    tag = "R10";
    cwrite(2, 2, mk(8'hFF, 0, 0, 0)); cwrite(0, 1, mk(8'h0F, 9, 11, 11));
    fetch(22);
    tag = "R8";
    quiet(); fetch_req = 1; fetch_rd = 5; ctx_sw = 1; ctx_new = 0; tick();
    ctx_sw = 0; tick(); quiet(); tick();
    tag = "R7"; fetch(6);                     // ctx0 programs retained
    tag = "R9";
    quiet(); fetch_req = 1; fetch_rd = 9; hw_we = 1; hw_idx = 8; hw_data = 32'h5555_AAAA;
    tick(); quiet(); tick();
    fetch(10);

    tag = "R5";
    for (int n = 0; n < 400; n++) begin
      hw_we = 1'($urandom); hw_idx = 5'($urandom); hw_data = $urandom;
      cfg_we = ($urandom % 4) == 0; cfg_ctx = 2'($urandom); cfg_row = 2'($urandom);
      cfg_word = 20'($urandom);
      ctx_sw = ($urandom % 5) == 0; ctx_new = 2'($urandom);
      fetch_req = 1'($urandom); fetch_rd = 5'($urandom);
      tick();
    end
    quiet(); tick();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule